// File: doc/BRIEF.md
# Counting ADC Conversion Controller

This block holds the digital side of a ramp-style analog-to-digital converter. A one-clock start request closes the sample-and-hold switch for a single cycle, then opens it so the analog input stays frozen on the hold capacitor. During that hold cycle the block clears its code register. From then on, the code drives an external DAC, and an external comparator reports whether the DAC voltage is still below the held input. The block adds one to the code on every clock while that report stays high.

The conversion finishes in one of two ways. Either the comparator reports that the DAC has reached the held input, or the code reaches full scale (all ones). At that point the block copies the code into the result register and raises a one-clock done pulse. Conversion time therefore depends on the input, from 3 to 4098 clocks after the start edge. The result stays put until the next conversion completes. A start request that arrives while a conversion is in progress has no effect.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, hold_o and done_o are 0 and dac_code_o and result_o are 0.
- R2: A start_i seen at a clock edge while idle sets hold_o to 1 for exactly the following cycle; hold_o is 0 in every other cycle.
- R3: In the cycle hold_o is 1, dac_code_o is 0. While counting, each clock with cmp_below_i = 1 (DAC below held input) and dac_code_o below 0xFFF raises dac_code_o by exactly one.
- R4: While counting, a clock with cmp_below_i = 0 ends the conversion: in the next cycle done_o is 1 and result_o equals the dac_code_o present when the comparator went low.
- R5: done_o is never high for two consecutive cycles.
- R6: result_o changes only in a cycle in which done_o is 1.
- R7: If dac_code_o reaches 0xFFF with cmp_below_i still 1, the code does not wrap, the conversion ends on the next clock and result_o is 0xFFF.
- R8: A start_i given while the hold or counting phase is in progress does not raise hold_o, does not restart the code, and does not change the final result.
- R9: For a held input at code level V (the comparator is high while code < V), done_o is seen min(V,4095)+3 cycles after the cycle in which start_i was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a conversion |
| cmp_below_i | input | 1 | Comparator: 1 while the DAC voltage is below the held input |
| hold_o | output | 1 | Sample switch control, 1 = switch closed (sampling) |
| dac_code_o | output | CODE_W (12) | Code driven to the external DAC |
| result_o | output | CODE_W (12) | Last completed conversion result |
| done_o | output | 1 | One-clock end-of-conversion pulse |

## Verification
The code register is visible on the DAC port, so a step error (missed count, double count, bad clear) shows up in the clock where it happens. The reference model comparison catches it there, before the result is produced. A phase-control fault shows up differently:
- an extra or missing hold cycle, or a restarted count, shifts the done pulse away from its predicted cycle;
- a wrongly captured code appears on result_o in the same cycle as done_o.

Saturation and busy-start faults only show up at the end of long conversions. The bench therefore runs a full-scale conversion, an over-range conversion, and conversions that receive a start request mid-count.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_COUNT = 2'd2
  } phase_e;
endpackage

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cmp_below_i,
  input  logic at_max_i,
  output logic clr_o,
  output logic inc_o,
  output logic fin_o,
  output logic counting_o,
  output logic hold_o,
  output logic done_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    fin_o   = 1'b0;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          phase_d = PH_HOLD;
        end
      end
      PH_HOLD: phase_d = PH_COUNT;
      PH_COUNT: begin
        if (cmp_below_i && !at_max_i) begin
          inc_o = 1'b1;
        end else begin
          fin_o   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      hold_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hold_o  <= clr_o;
      done_o  <= fin_o;
    end
  end

  assign counting_o = (phase_q == PH_COUNT);

  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> !hold_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && (hold_o || counting_o)) |=> !hold_o); // R8
endmodule

// File: rtl/ramp_adc_count.sv
module ramp_adc_count #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_max_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      code_o <= '0;
    end else if (inc_i) begin
      code_o <= code_o + 1'b1;
    end
  end

  assign at_max_o = (code_o == CODE_MAX);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (at_max_o && !clr_i) |=> at_max_o); // R7
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_below_i,
  output logic              hold_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] result_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic clr, inc, fin, at_max, counting;

  ramp_adc_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cmp_below_i(cmp_below_i),
    .at_max_i   (at_max),
    .clr_o      (clr),
    .inc_o      (inc),
    .fin_o      (fin),
    .counting_o (counting),
    .hold_o     (hold_o),
    .done_o     (done_o)
  );

  ramp_adc_count #(.CODE_W(CODE_W)) i_count (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .inc_i   (inc),
    .code_o  (dac_code_o),
    .at_max_o(at_max)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
    end else if (fin) begin
      result_o <= dac_code_o;
    end
  end

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
    (counting && cmp_below_i && dac_code_o != CODE_MAX)
      |=> (dac_code_o == $past(dac_code_o) + 1'b1)); // R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> (dac_code_o == '0)); // R3
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R6
  AST_STOP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (counting && !cmp_below_i) |=> (done_o && result_o == $past(dac_code_o))); // R4
endmodule

// File: tb/test_ramp_adc_ctrl.sv
module test_ramp_adc_ctrl;
  localparam int W = 12;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cmp_below_i;
  logic hold_o, done_o;
  logic [W-1:0] dac_code_o, result_o;

  int vin = 0;
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  // analog model: comparator high while DAC level below held input
  assign cmp_below_i = (int'(dac_code_o) < vin);

  ramp_adc_ctrl #(.CODE_W(W)) i_ramp_adc_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_below_i(cmp_below_i),
    .hold_o(hold_o), .dac_code_o(dac_code_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_phase = 0, m_code = 0, m_res = 0;
  bit m_done = 0, m_hold = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_phase = 0; m_code = 0; m_res = 0; m_done = 0; m_hold = 0;
    end else begin
      m_done = 0;
      m_hold = 0;
      if (m_phase == 0) begin
        if (start_i) begin m_phase = 1; m_hold = 1; m_code = 0; end
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else begin
        if (m_code < vin && m_code < FULL) m_code = m_code + 1;
        else begin m_res = m_code; m_done = 1; m_phase = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(hold_o == m_hold, "R2 hold", int'(hold_o), int'(m_hold));
      check(int'(dac_code_o) == m_code, "R3 code", int'(dac_code_o), m_code);
      check(done_o == m_done, "R5 done", int'(done_o), int'(m_done));
      check(int'(result_o) == m_res, "R6 result", int'(result_o), m_res);
    end
  end

  always @(posedge clk) begin
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic convert(input int v, input int poke_at);
    int lat = 0;
    int expv = (v > FULL) ? FULL : v;
    vin = v;
    @(negedge clk);
    start_i = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
      if (poke_at > 0 && lat == poke_at) begin
        start_i = 1'b1; // R8: request while busy
        @(negedge clk);
        start_i = 1'b0;
        lat++;
        check(!hold_o, "R8 hold stays open", int'(hold_o), 0);
      end
      if (done_o) break;
    end
    check(int'(result_o) == expv, (v > FULL) ? "R7 saturate" : "R4 result", int'(result_o), expv);
    check(lat == expv + 3, "R9 latency", lat, expv + 3);
    @(negedge clk);
    check(!done_o, "R5 single pulse", int'(done_o), 0);
    check(int'(result_o) == expv, "R6 held", int'(result_o), expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!hold_o && !done_o, "R1 flags", int'({hold_o, done_o}), 0);
    check(dac_code_o == '0 && result_o == '0, "R1 regs", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!hold_o && !done_o && result_o == '0, "R1 after release", int'(result_o), 0);
    convert(0, 0);
    convert(1, 0);
    convert(37, 0);
    convert(300, 20);
    convert(2, 1);
    convert(FULL - 1, 0);
    convert(FULL, 0);
    convert(5000, 100);   // R7 over-range
    vin = 900;
    repeat (10) @(negedge clk);
    check(int'(result_o) == FULL, "R6 idle stable", int'(result_o), FULL);
    convert(12, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule